// File: doc/BRIEF.md
# Multi-Page-Size Data Translation Buffer

This block translates data-side virtual addresses into physical addresses through a small, fully associative set of mapping slots. Each slot holds its own page granularity, one of four sizes. The page size sets how many low address bits are left out of the tag comparison. Those same bits are carried unchanged from the virtual address into the physical one. Each slot also holds separate read and write permission bits. A lookup that finds no matching valid slot reports a miss. Software handles the miss, installs a new mapping through the fill port and retries the access. No hardware page walk exists.

A fill always goes to the slot selected by an internal rotating pointer. Software can clear one slot by index, or clear every slot at once. Lookup results are registered and appear one clock after the request.

Top module: `dxtb`

## Requirements
- R1: The buffer has 32 slots. After a fill, a lookup of any address inside that page hits, whichever slot the fill used.
- R2: The fill_size code picks the page granularity: 0 gives 8 KB (13 offset bits), 1 gives 64 KB (16), 2 gives 512 KB (19) and 3 gives 4 MB (22). Virtual bits 42 down to the offset width must equal the slot's stored tag. Physical bits 33 down to the offset width come from the slot, and the bits below come unchanged from lk_va.
- R3: A lookup that matches no valid slot returns res_hit=0, res_fault=0, res_ok=0 and res_pa=0.
- R4: A hit with lk_write=0 on a slot whose read bit is 0, or with lk_write=1 on a slot whose write bit is 0, returns res_fault=1 and res_ok=0. A permitted hit returns res_ok=1 and res_fault=0.
- R5: When several valid slots match, the result comes only from the lowest-numbered one.
- R6: Fills go to slot 0 first after reset. The pointer then steps by one per accepted fill and wraps from 31 to 0.
- R7: inv_one clears the valid bit of slot inv_idx. If a fill targets that same slot in the same cycle, the slot ends up invalid and the pointer still advances.
- R8: inv_all clears every slot in one cycle. A fill in that same cycle is dropped and does not move the pointer.
- R9: res_valid is high exactly one cycle after lk_valid. A lookup sees the slot contents from before any fill or clear taken at that same edge.
- R10: During and after reset all slots are invalid and res_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 43 | Virtual address to translate |
| lk_write | input | 1 | 1 = write access, 0 = read access |
| res_valid | output | 1 | Result present (one cycle after request) |
| res_hit | output | 1 | A valid slot matched |
| res_fault | output | 1 | Matched slot forbids this access type |
| res_ok | output | 1 | Translation usable |
| res_pa | output | 34 | Translated physical address, 0 on miss |
| fill_en | input | 1 | Install a mapping at the pointer slot |
| fill_va | input | 43 | Virtual page address of the new mapping |
| fill_pa | input | 34 | Physical page address of the new mapping |
| fill_size | input | 2 | Page size code |
| fill_rd | input | 1 | Read permitted |
| fill_wr | input | 1 | Write permitted |
| inv_one | input | 1 | Clear one slot |
| inv_idx | input | 5 | Slot to clear |
| inv_all | input | 1 | Clear all slots |

## Verification
The bench fills all 32 slots, cycling through the four page sizes and a spread of permission pairs. It probes each page at its first byte, its last byte, a middle offset and the addresses just outside it. This separates a wrong offset width from a wrong tag compare, and a read-permission bug from a write-permission bug. Deliberately overlapping pages check that the lowest slot wins and that removing it exposes the next match. Fills that land in the same cycle as a single-slot clear, a full clear or a lookup show the ordering rules. A following fill, clear and probe reveal where the pointer stands.

// File: rtl/dxtb_pkg.sv
package dxtb_pkg;
   typedef enum logic [1:0] {
      PG_8K   = 2'd0,
      PG_64K  = 2'd1,
      PG_512K = 2'd2,
      PG_4M   = 2'd3
   } pg_size_e;

   localparam int PG_CODES = 4;
endpackage

// File: rtl/dxtb_rr.sv
module dxtb_rr #(
   parameter int N     = 32,
   parameter int IDX_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   output logic [IDX_W-1:0] ptr
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

   always_ff @(posedge clk) begin
      if (!rst_n)
         ptr <= '0;
      else if (adv)
         ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
   end

   // R6: pointer only moves on an accepted fill
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(ptr));
   a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      adv && ptr == LAST |=> ptr == '0);
endmodule

// File: rtl/dxtb_slot.sv
module dxtb_slot
   import dxtb_pkg::*;
#(
   parameter int VA_W = 43,
   parameter int PA_W = 34,
   parameter int OFF0 = 13,
   parameter int STEP = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 load,
   input  logic [VA_W-1:OFF0]   ld_tag,
   input  logic [PA_W-1:OFF0]   ld_pfn,
   input  pg_size_e             ld_size,
   input  logic                 ld_rd,
   input  logic                 ld_wr,
   input  logic [VA_W-1:0]      q_va,
   output logic                 hit,
   output logic [PA_W-1:0]      q_pa,
   output logic                 perm_rd,
   output logic                 perm_wr,
   output logic                 vld
);
   logic [VA_W-1:OFF0] tag_q;
   logic [PA_W-1:OFF0] pfn_q;
   pg_size_e           size_q;
   logic [PA_W-1:0]    base;
   logic               diff;
   int                 off_w;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld     <= 1'b0;
         tag_q   <= '0;
         pfn_q   <= '0;
         size_q  <= PG_8K;
         perm_rd <= 1'b0;
         perm_wr <= 1'b0;
      end else begin
         if (load) begin
            vld     <= 1'b1;
            tag_q   <= ld_tag;
            pfn_q   <= ld_pfn;
            size_q  <= ld_size;
            perm_rd <= ld_rd;
            perm_wr <= ld_wr;
         end
         if (clr)
            vld <= 1'b0;
      end
   end

   always_comb begin
      off_w = OFF0 + STEP * int'(size_q);
      base  = {pfn_q, {OFF0{1'b0}}};
      diff  = 1'b0;
      for (int b = OFF0; b < VA_W; b++)
         if (b >= off_w && tag_q[b] != q_va[b])
            diff = 1'b1;
      for (int b = 0; b < PA_W; b++)
         q_pa[b] = (b < off_w) ? q_va[b] : base[b];
      hit = vld && !diff;
   end

   // R7: a cleared slot is invalid on the next cycle
   a_r7_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !vld);
endmodule

// File: rtl/dxtb_pick.sv
module dxtb_pick #(
   parameter int N = 32,
   parameter int W = 34
) (
   input  logic [N-1:0]   hit_v,
   input  logic [N*W-1:0] pa_flat,
   input  logic [N-1:0]   rd_v,
   input  logic [N-1:0]   wr_v,
   output logic           any,
   output logic [W-1:0]   pa,
   output logic           rd,
   output logic           wr,
   output logic [N-1:0]   grant
);
   logic found;

   always_comb begin
      grant = '0;
      found = 1'b0;
      for (int i = 0; i < N; i++)
         if (hit_v[i] && !found) begin
            grant[i] = 1'b1;
            found    = 1'b1;
         end
      any = found;
      pa  = '0;
      rd  = 1'b0;
      wr  = 1'b0;
      for (int i = 0; i < N; i++)
         if (grant[i]) begin
            pa = pa | pa_flat[i*W +: W];
            rd = rd | rd_v[i];
            wr = wr | wr_v[i];
         end
   end
endmodule

// File: rtl/dxtb.sv
module dxtb
   import dxtb_pkg::*;
#(
   parameter int ENTRIES = 32,
   parameter int VA_W    = 43,
   parameter int PA_W    = 34,
   parameter int OFF0    = 13,
   parameter int STEP    = 3,
   localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lk_valid,
   input  logic [VA_W-1:0]  lk_va,
   input  logic             lk_write,
   output logic             res_valid,
   output logic             res_hit,
   output logic             res_fault,
   output logic             res_ok,
   output logic [PA_W-1:0]  res_pa,
   input  logic             fill_en,
   input  logic [VA_W-1:0]  fill_va,
   input  logic [PA_W-1:0]  fill_pa,
   input  logic [1:0]       fill_size,
   input  logic             fill_rd,
   input  logic             fill_wr,
   input  logic             inv_one,
   input  logic [IDX_W-1:0] inv_idx,
   input  logic             inv_all
);
   localparam int MAX_OFF = OFF0 + STEP * (PG_CODES - 1);

   if (ENTRIES < 2) begin : g_bad_entries
      $error("dxtb: ENTRIES must be at least 2");
   end
   if (MAX_OFF >= PA_W || MAX_OFF >= VA_W) begin : g_bad_offset
      $error("dxtb: largest page offset must be narrower than both addresses");
   end

   logic [IDX_W-1:0]      ptr;
   logic                  adv;
   logic [ENTRIES-1:0]    hit_v, rd_v, wr_v, vld_v, grant;
   logic [ENTRIES*PA_W-1:0] pa_flat;
   logic                  any_hit, sel_rd, sel_wr, flt;
   logic [PA_W-1:0]       sel_pa;

   assign adv = fill_en && !inv_all;

   dxtb_rr #(.N(ENTRIES), .IDX_W(IDX_W)) u_rr (
      .clk(clk), .rst_n(rst_n), .adv(adv), .ptr(ptr)
   );

   for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
      logic clr_g, load_g;
      assign clr_g  = inv_all || (inv_one && inv_idx == IDX_W'(g));
      assign load_g = adv && ptr == IDX_W'(g);

      dxtb_slot #(.VA_W(VA_W), .PA_W(PA_W), .OFF0(OFF0), .STEP(STEP)) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr     (clr_g),
         .load    (load_g),
         .ld_tag  (fill_va[VA_W-1:OFF0]),
         .ld_pfn  (fill_pa[PA_W-1:OFF0]),
         .ld_size (pg_size_e'(fill_size)),
         .ld_rd   (fill_rd),
         .ld_wr   (fill_wr),
         .q_va    (lk_va),
         .hit     (hit_v[g]),
         .q_pa    (pa_flat[g*PA_W +: PA_W]),
         .perm_rd (rd_v[g]),
         .perm_wr (wr_v[g]),
         .vld     (vld_v[g])
      );
   end

   dxtb_pick #(.N(ENTRIES), .W(PA_W)) u_pick (
      .hit_v(hit_v), .pa_flat(pa_flat), .rd_v(rd_v), .wr_v(wr_v),
      .any(any_hit), .pa(sel_pa), .rd(sel_rd), .wr(sel_wr), .grant(grant)
   );

   assign flt = any_hit && (lk_write ? !sel_wr : !sel_rd);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_hit   <= 1'b0;
         res_fault <= 1'b0;
         res_ok    <= 1'b0;
         res_pa    <= '0;
      end else begin
         res_valid <= lk_valid;
         res_hit   <= lk_valid && any_hit;
         res_fault <= lk_valid && flt;
         res_ok    <= lk_valid && any_hit && !flt;
         res_pa    <= (lk_valid && any_hit) ? sel_pa : '0;
      end
   end

   // R5: at most one winner, and a winner whenever any slot matches
   a_r5_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant) && ((grant == '0) == (hit_v == '0)));
   // R3: a miss returns nothing usable
   a_r3_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && !res_hit |-> !res_fault && !res_ok && res_pa == '0);
   // R4: usable and faulting are exclusive and need a hit
   a_r4_ok_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
      res_ok |-> res_hit && !res_fault);
   // R2: the smallest offset always passes through
   a_r2_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> !res_hit || res_pa[OFF0-1:0] == $past(lk_va[OFF0-1:0]));
   // R8: full clear empties every slot in one cycle
   a_r8_flush: assert property (@(posedge clk) disable iff (!rst_n)
      inv_all |=> vld_v == '0);
endmodule

// File: tb/dxtb_tb.sv
module dxtb_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0, lk_write = 1'b0;
   logic [42:0] lk_va = '0;
   logic        res_valid, res_hit, res_fault, res_ok;
   logic [33:0] res_pa;
   logic        fill_en = 1'b0, fill_rd = 1'b0, fill_wr = 1'b0;
   logic [42:0] fill_va = '0;
   logic [33:0] fill_pa = '0;
   logic [1:0]  fill_size = '0;
   logic        inv_one = 1'b0, inv_all = 1'b0;
   logic [4:0]  inv_idx = '0;

   int checks = 0, errors = 0;
   bit done = 0;

   logic [42:0] m_va[32];
   logic [33:0] m_pa[32];
   int          m_sz[32];
   bit          m_rd[32], m_wr[32], m_v[32];
   int          m_ptr = 0;

   always #10 clk = ~clk;

   dxtb u_dut (
      .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_va(lk_va), .lk_write(lk_write),
      .res_valid(res_valid), .res_hit(res_hit), .res_fault(res_fault), .res_ok(res_ok),
      .res_pa(res_pa), .fill_en(fill_en), .fill_va(fill_va), .fill_pa(fill_pa),
      .fill_size(fill_size), .fill_rd(fill_rd), .fill_wr(fill_wr), .inv_one(inv_one),
      .inv_idx(inv_idx), .inv_all(inv_all)
   );

   function automatic void model_lookup(input logic [42:0] va, input bit w,
                                        output bit h, output bit f, output bit o,
                                        output logic [33:0] pa);
      h = 0; f = 0; o = 0; pa = '0;
      for (int i = 0; i < 32; i++) begin
         if (m_v[i]) begin
            int off = 13 + 3 * m_sz[i];
            if ((longint'(va) >> off) == (longint'(m_va[i]) >> off)) begin
               h  = 1;
               pa = 34'(((longint'(m_pa[i]) >> off) << off) |
                        (longint'(va) & ((64'sd1 << off) - 1)));
               f  = w ? !m_wr[i] : !m_rd[i];
               o  = !f;
               break;
            end
         end
      end
   endfunction

   task automatic check(input bit cond, input string tag, input string what);
      checks++;
      if (!cond) begin
         errors++;
         $display("FAIL %s %s", tag, what);
      end
   endtask

   task automatic cyc(input bit lv, input logic [42:0] va, input bit w,
                      input bit fe, input logic [42:0] fva, input logic [33:0] fpa,
                      input int fsz, input bit frd, input bit fwr,
                      input bit io, input int ii, input bit ia, input string tag);
      bit eh, ef, eo;
      logic [33:0] ep;
      @(negedge clk);
      lk_valid = lv; lk_va = va; lk_write = w;
      fill_en = fe; fill_va = fva; fill_pa = fpa; fill_size = 2'(fsz);
      fill_rd = frd; fill_wr = fwr;
      inv_one = io; inv_idx = 5'(ii); inv_all = ia;
      model_lookup(va, w, eh, ef, eo, ep);
      @(posedge clk);
      if (ia) begin
         for (int i = 0; i < 32; i++) m_v[i] = 0;
      end else begin
         if (fe) begin
            m_va[m_ptr] = fva; m_pa[m_ptr] = fpa; m_sz[m_ptr] = fsz;
            m_rd[m_ptr] = frd; m_wr[m_ptr] = fwr; m_v[m_ptr] = 1;
            m_ptr = (m_ptr + 1) % 32;
         end
         if (io) m_v[ii] = 0;
      end
      @(negedge clk);
      if (lv)
         check(res_valid && res_hit == eh && res_fault == ef && res_ok == eo && res_pa == ep,
               tag, $sformatf("va=%h w=%0d got v=%0d h=%0d f=%0d o=%0d pa=%h exp h=%0d f=%0d o=%0d pa=%h",
                              va, w, res_valid, res_hit, res_fault, res_ok, res_pa, eh, ef, eo, ep));
      else
         check(!res_valid, "R9", $sformatf("res_valid got %0d exp 0", res_valid));
      lk_valid = 0; fill_en = 0; inv_one = 0; inv_all = 0;
   endtask

   task automatic look(input logic [42:0] va, input bit w, input string tag);
      cyc(1, va, w, 0, '0, '0, 0, 0, 0, 0, 0, 0, tag);
   endtask

   task automatic fill(input logic [42:0] va, input logic [33:0] pa, input int sz,
                       input bit rd, input bit wr, input string tag);
      cyc(0, '0, 0, 1, va, pa, sz, rd, wr, 0, 0, 0, tag);
   endtask

   function automatic logic [42:0] base_va(input int i);
      return 43'((longint'(i + 1) << 22) | (longint'(i * 5) << 13));
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 32; i++) m_v[i] = 0;
      repeat (4) @(negedge clk);
      check(!res_valid && !res_hit, "R10", $sformatf("reset res_valid=%0d res_hit=%0d exp 0", res_valid, res_hit));
      rst_n = 1'b1;
      look(43'h0, 0, "R10");
      look(base_va(3), 1, "R3");

      // R6 R1: fill every slot, sizes and permissions rotating
      for (int i = 0; i < 32; i++)
         fill(base_va(i), 34'((longint'(i * 7 + 3) << 13) | 34'h2_0000_0000), i % 4,
              (i % 3) != 1, (i % 2) == 0, "R6");

      // R1 R2 R4: probe each page inside and at its edges
      for (int i = 0; i < 32; i++) begin
         longint pg = longint'(1) << (13 + 3 * (i % 4));
         longint b  = (longint'(base_va(i)) / pg) * pg;
         look(43'(b), 0, "R1");
         look(43'(b + pg - 1), 1, "R4");
         look(43'(b + pg / 3), 0, "R2");
         look(43'(b + pg), 0, "R2");
         look(43'(b - 1), 1, "R2");
      end
      look(43'(longint'(40) << 22), 0, "R3");

      // R5: slot 0 re-filled with a 4 MB page covering slot 5's page
      fill(base_va(5), 34'h3_0040_0000, 3, 1, 0, "R6");
      look(base_va(5), 0, "R5");
      look(base_va(5), 1, "R5");
      look(base_va(5) + 43'h1234, 0, "R5");

      // R7: removing slot 0 exposes slot 5; clear beats a same-slot fill
      cyc(0, '0, 0, 0, '0, '0, 0, 0, 0, 1, 0, 0, "R7");
      look(base_va(5), 0, "R7");
      cyc(0, '0, 0, 1, 43'h7_0000_0000, 34'h1_2345_6000, 0, 1, 1, 1, m_ptr, 0, "R7");
      look(43'h7_0000_0000, 0, "R7");

      // R9: lookup in the fill cycle sees the old contents
      cyc(1, 43'h7_1000_0000, 0, 1, 43'h7_1000_0000, 34'h0_4444_0000, 1, 1, 1, 0, 0, 0, "R9");
      look(43'h7_1000_0000, 0, "R9");
      look(43'h7_1000_fff0, 1, "R9");

      // R8: full clear drops the fill and keeps the pointer
      cyc(0, '0, 0, 1, 43'h7_2000_0000, 34'h0_5555_0000, 2, 1, 1, 0, 0, 1, "R8");
      look(43'h7_2000_0000, 0, "R8");
      for (int i = 0; i < 32; i++) look(base_va(i), 0, "R8");
      fill(43'h7_3000_0000, 34'h0_6666_0000, 0, 1, 1, "R8");
      look(43'h7_3000_0000, 0, "R8");
      cyc(0, '0, 0, 0, '0, '0, 0, 0, 0, 1, (m_ptr + 31) % 32, 0, "R8");
      look(43'h7_3000_0000, 0, "R8");

      // R6: a long run of fills wraps the pointer; stale slots are overwritten
      for (int i = 0; i < 40; i++)
         fill(base_va(i % 32), 34'(longint'(i) << 22), (i + 1) % 4, 1, i % 2, "R6");
      for (int i = 0; i < 32; i++) look(base_va(i) + 43'h10, i % 2, "R6");

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule